// File: doc/BRIEF.md
# Frame Sync Rate Generator

This block is the timing master of a serial audio port. It divides the functional clock by a programmable amount to make a bit clock. It then counts bit clocks to make a periodic frame-sync pulse whose frame length and pulse width are both programmable. A one-cycle frame-start strobe marks the first functional-clock cycle of every frame, so a data path running on the same clock can align itself to it.

Software picks the pulse width to suit the framing. For I2S or left-justified framing the width is half the frame, for example a period field of 31 with a width field of 15. For DSP-style framing the width is a single bit clock, which is a width field of 0. The divider, period and width are sampled when the block is enabled. After that they are sampled again only at each frame boundary, so a change never gives a torn frame.

On request, the block checks whether the programmed frame is long enough to carry word length × channel count bits. It records the result in a sticky configuration-error flag.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the block is enabled, bitClk, frameSync, frameStart and cfgErr are all 0.
- R2: On the first clock edge at which enable is sampled high after being low, the bit and frame counters restart. The divider, period and width inputs are captured at that edge. frameStart is high in the cycle that follows.
- R3: With a divider field D > 0, the bit period is N = D+1 clock cycles. Each bit period starts with floor(N/2) cycles of bitClk high, followed by ceil(N/2) cycles of bitClk low.
- R4: With a divider field of 0, bitClk equals the functional clock while the block runs, and 0 otherwise.
- R5: A frame lasts P+1 bit periods, where P is the 12-bit period field. frameStart is high for exactly the first clock cycle of each frame.
- R6: frameSync is high for the first W+1 bit periods of each frame, where W is the 8-bit width field. When W ≥ P, frameSync stays high for the whole frame.
- R7: Changes to the divider, period or width inputs while the block runs take effect only from the first cycle of the next frame.
- R8: One clock edge after enable is sampled low, bitClk, frameSync and frameStart are 0.
- R9: At a clock edge with checkReq high, cfgErr is loaded with 1 if P+1 < wordBits × chanCount, and with 0 otherwise. At every other edge cfgErr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; a rising level restarts the frame |
| clkDiv | input | 8 | Bit clock divider field (divide by value+1) |
| framePeriod | input | 12 | Bit clocks per frame minus one |
| syncWidth | input | 8 | Frame-sync width in bit clocks minus one |
| checkReq | input | 1 | Evaluate the bandwidth check this cycle |
| wordBits | input | 6 | Word length in bits, for the bandwidth check |
| chanCount | input | 5 | Channels per frame, for the bandwidth check |
| bitClk | output | 1 | Bit clock |
| frameSync | output | 1 | Frame-sync pulse |
| frameStart | output | 1 | One-cycle strobe at the first cycle of each frame |
| cfgErr | output | 1 | Frame too short for word length × channels |

## Verification
The hardest case to reach is a configuration change made in the middle of a running frame. The old frame must still finish with its old divider, period and width, and the new values must govern only from the next boundary. The stimulus starts a frame with one setting. A few cycles later, well inside the first frame, it switches all three fields to different values, including a divider of 0 that swaps the registered bit clock for the gated one. Every cycle is then compared with a piecewise expectation that changes at the computed boundary cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic restart;    // first edge of a run: counters clear, fields captured
    logic running;    // generator active
    logic bitWrap;    // last clock cycle of the current bit period
    logic phaseZero;  // first clock cycle of the current bit period
  } fsgStrobe_t;
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             frameLast,
  output fsgStrobe_t       strb,
  output logic             bitClk
);
  localparam int PH_W = DIV_W + 1;

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [PH_W-1:0]  halfLen;
  logic             restart;
  logic             bitWrap;

  assign restart = enable & ~running;
  assign bitWrap = running & (divCnt == divLat);
  assign halfLen = ({1'b0, divLat} + PH_W'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      divLat  <= '0;
    end else begin
      running <= enable;
      if (restart) begin
        divCnt <= '0;
        divLat <= clkDiv;
      end else if (running) begin
        if (bitWrap) begin
          divCnt <= '0;
          if (frameLast) divLat <= clkDiv;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // Divide-by-one passes the gated clock; otherwise high phase comes first
  always_comb begin
    if (divLat == '0) bitClk = clk & running;
    else              bitClk = running & ({1'b0, divCnt} < halfLen);
  end

  assign strb.restart   = restart;
  assign strb.running   = running;
  assign strb.bitWrap   = bitWrap;
  assign strb.phaseZero = (divCnt == '0);
endmodule

// File: rtl/fsg_dpath.sv
module fsg_dpath
  import fsg_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int WID_W  = 8,
  parameter int WLEN_W = 6,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsgStrobe_t        strb,
  input  logic [PER_W-1:0]  framePeriod,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic              checkReq,
  input  logic [WLEN_W-1:0] wordBits,
  input  logic [CHAN_W-1:0] chanCount,
  output logic              frameLast,
  output logic              frameSync,
  output logic              frameStart,
  output logic              cfgErr
);
  localparam int PROD_W = WLEN_W + CHAN_W;
  localparam int CMP_W  = ((PER_W + 1) > PROD_W) ? (PER_W + 1) : PROD_W;
  localparam int SW_W   = (PER_W > WID_W) ? PER_W : WID_W;

  logic [PER_W-1:0]  bitCnt;
  logic [PER_W-1:0]  perLat;
  logic [WID_W-1:0]  widLat;
  logic [PROD_W-1:0] needBits;
  logic [CMP_W-1:0]  haveBits;

  assign frameLast = (bitCnt == perLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      perLat <= '0;
      widLat <= '0;
    end else if (strb.restart) begin
      bitCnt <= '0;
      perLat <= framePeriod;
      widLat <= syncWidth;
    end else if (strb.running && strb.bitWrap) begin
      if (frameLast) begin
        bitCnt <= '0;
        perLat <= framePeriod;
        widLat <= syncWidth;
      end else begin
        bitCnt <= bitCnt + PER_W'(1);
      end
    end
  end

  assign frameSync  = strb.running & (SW_W'(bitCnt) <= SW_W'(widLat));
  assign frameStart = strb.running & (bitCnt == '0) & strb.phaseZero;

  // Bandwidth check: bits in a frame against word length times channels
  assign needBits = PROD_W'(wordBits) * PROD_W'(chanCount);
  assign haveBits = CMP_W'(framePeriod) + CMP_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)         cfgErr <= 1'b0;
    else if (checkReq) cfgErr <= (haveBits < CMP_W'(needBits));
  end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 12,
  parameter int WID_W  = 8,
  parameter int WLEN_W = 6,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [PER_W-1:0]  framePeriod,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic              checkReq,
  input  logic [WLEN_W-1:0] wordBits,
  input  logic [CHAN_W-1:0] chanCount,
  output logic              bitClk,
  output logic              frameSync,
  output logic              frameStart,
  output logic              cfgErr
);
  fsgStrobe_t strb;
  logic       frameLast;

  fsg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .clkDiv    (clkDiv),
    .frameLast (frameLast),
    .strb      (strb),
    .bitClk    (bitClk)
  );

  fsg_dpath #(
    .PER_W (PER_W),
    .WID_W (WID_W),
    .WLEN_W(WLEN_W),
    .CHAN_W(CHAN_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .framePeriod (framePeriod),
    .syncWidth   (syncWidth),
    .checkReq    (checkReq),
    .wordBits    (wordBits),
    .chanCount   (chanCount),
    .frameLast   (frameLast),
    .frameSync   (frameSync),
    .frameStart  (frameStart),
    .cfgErr      (cfgErr)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic checkReq,
  input logic bitClk,
  input logic frameSync,
  input logic frameStart,
  input logic cfgErr
);
  // R2: a rising enable yields a frame start in the following cycle
  p_start_after_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> frameStart);

  // R6: every frame opens with the sync pulse active
  p_sync_at_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> frameSync);

  // R8: a low enable silences the frame outputs one edge later
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!frameSync && !frameStart));

  // R9: the error flag only moves on a check request
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !checkReq |=> $stable(cfgErr));

  // R1: nothing is produced while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!frameSync && !frameStart && !cfgErr));
endmodule

bind frame_sync_gen fsg_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .checkReq   (checkReq),
  .bitClk     (bitClk),
  .frameSync  (frameSync),
  .frameStart (frameStart),
  .cfgErr     (cfgErr)
);

// File: tb/sim_frame_sync_gen.sv
`timescale 1ns/1ps
module sim_frame_sync_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  clkDiv = '0;
  logic [11:0] framePeriod = '0;
  logic [7:0]  syncWidth = '0;
  logic        checkReq = 1'b0;
  logic [5:0]  wordBits = '0;
  logic [4:0]  chanCount = '0;
  logic        bitClk, frameSync, frameStart, cfgErr;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  frame_sync_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .framePeriod(framePeriod), .syncWidth(syncWidth), .checkReq(checkReq),
    .wordBits(wordBits), .chanCount(chanCount), .bitClk(bitClk),
    .frameSync(frameSync), .frameStart(frameStart), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sample point: 5 ns after a rising edge (clock high)
  task automatic stepHigh();
    @(posedge clk); #5;
  endtask

  // Expected outputs for a constant setting, c cycles after the start cycle
  function automatic int expBit(int d, int c);
    int n = d + 1;
    if (d == 0) return 1;  // sampled while clk is high
    return ((c % n) < (n / 2)) ? 1 : 0;
  endfunction
  function automatic int expSync(int d, int p, int w, int c);
    int idx = (c / (d + 1)) % (p + 1);
    return (idx <= w) ? 1 : 0;
  endfunction
  function automatic int expStart(int d, int p, int c);
    int n = d + 1;
    return (((c / n) % (p + 1)) == 0 && (c % n) == 0) ? 1 : 0;
  endfunction

  // Restart the generator with one setting and compare every cycle (R2 R3 R4 R5 R6)
  task automatic runPattern(input int d, input int p, input int w, input int cycles);
    int badBit = 0, badSync = 0, badStart = 0, badLow = 0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    clkDiv = 8'(d); framePeriod = 12'(p); syncWidth = 8'(w);
    enable = 1'b1;
    stepHigh();
    check("R2", "frameStart after enable", int'(frameStart), 1);
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) stepHigh();
      if (int'(bitClk) != expBit(d, c) && badBit == 0) begin
        badBit = 1;
        check(d == 0 ? "R4" : "R3", $sformatf("bitClk c=%0d d=%0d", c, d), int'(bitClk), expBit(d, c));
      end
      if (int'(frameSync) != expSync(d, p, w, c) && badSync == 0) begin
        badSync = 1;
        check("R6", $sformatf("frameSync c=%0d", c), int'(frameSync), expSync(d, p, w, c));
      end
      if (int'(frameStart) != expStart(d, p, c) && badStart == 0) begin
        badStart = 1;
        check("R5", $sformatf("frameStart c=%0d", c), int'(frameStart), expStart(d, p, c));
      end
      if (d == 0) begin
        #10;
        if (bitClk !== 1'b0 && badLow == 0) begin
          badLow = 1;
          check("R4", "bitClk in low clock phase", int'(bitClk), 0);
        end
      end
    end
    if (badBit == 0)   check(d == 0 ? "R4" : "R3", "bitClk waveform", 0, 0);
    if (badSync == 0)  check("R6", "frameSync waveform", 0, 0);
    if (badStart == 0) check("R5", "frameStart waveform", 0, 0);
    if (d == 0 && badLow == 0) check("R4", "bitClk low phase", 0, 0);
  endtask

  task automatic testReset();
    #3;
    check("R1", "bitClk in reset", int'(bitClk), 0);
    check("R1", "frameSync in reset", int'(frameSync), 0);
    check("R1", "cfgErr in reset", int'(cfgErr), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    stepHigh();
    check("R1", "frameStart idle", int'(frameStart), 0);
    check("R1", "frameSync idle", int'(frameSync), 0);
  endtask

  // Mid-frame change: old frame finishes, new setting from the boundary (R7)
  task automatic testBoundary();
    int bad = 0;
    int c, ed, ep, ew, cc;
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    clkDiv = 8'd1; framePeriod = 12'd3; syncWidth = 8'd1; enable = 1'b1;
    for (c = 0; c < 26; c++) begin
      stepHigh();
      if (c < 8) begin ed = 1; ep = 3; ew = 1; cc = c; end
      else       begin ed = 0; ep = 5; ew = 2; cc = c - 8; end
      if (bad == 0 && (int'(bitClk) != expBit(ed, cc) ||
                       int'(frameSync) != expSync(ed, ep, ew, cc) ||
                       int'(frameStart) != expStart(ed, ep, cc))) begin
        bad = 1;
        check("R7", $sformatf("outputs {bit,sync,start} c=%0d", c),
              int'({bitClk, frameSync, frameStart}),
              expBit(ed, cc) * 4 + expSync(ed, ep, ew, cc) * 2 + expStart(ed, ep, cc));
      end
      if (c == 2) begin
        #10;
        clkDiv = 8'd0; framePeriod = 12'd5; syncWidth = 8'd2;
      end
    end
    if (bad == 0) check("R7", "boundary switch", 0, 0);
  endtask

  task automatic testDisable();
    @(negedge clk); enable = 1'b0;
    stepHigh();
    check("R8", "frameSync after disable", int'(frameSync), 0);
    check("R8", "frameStart after disable", int'(frameStart), 0);
    check("R8", "bitClk after disable", int'(bitClk), 0);
  endtask

  task automatic doCheck(input int p, input int wb, input int ch, input int exp);
    @(negedge clk);
    framePeriod = 12'(p); wordBits = 6'(wb); chanCount = 5'(ch); checkReq = 1'b1;
    @(negedge clk); checkReq = 1'b0;
    check("R9", $sformatf("cfgErr p=%0d %0dx%0d", p, wb, ch), int'(cfgErr), exp);
  endtask

  task automatic testBandwidth();
    doCheck(31, 16, 2, 0);   // 32 bits carry 32: enough
    doCheck(30, 16, 2, 1);   // 31 bits short of 32
    @(negedge clk); framePeriod = 12'd4000;
    @(negedge clk);
    check("R9", "cfgErr holds without request", int'(cfgErr), 1);
    doCheck(255, 32, 8, 0);  // exact fit
    doCheck(100, 63, 31, 1);
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    runPattern(3, 7, 3, 80);    // even divider, half-frame sync
    runPattern(2, 4, 0, 45);    // odd divider, one-bit sync
    runPattern(0, 31, 15, 70);  // divide-by-one, half-frame
    runPattern(4, 2, 9, 40);    // width beyond period: sync whole frame
    runPattern(0, 0, 0, 6);     // one-bit frame: start every cycle
    testBoundary();
    testDisable();
    testBandwidth();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule